// File: doc/BRIEF.md
# Serial Control Register File with Staged Commit

This block receives write-only control frames over a three-wire serial link (active-low select, serial clock, serial data) and keeps the register set that configures a two-channel driver. Every frame is sixteen bits: a four-bit address on top and twelve bits of data below. The three link inputs are brought into the system clock domain through synchronizer chains. Edges are detected after synchronization, so every register update happens on a system clock edge.

Registers update in one of three ways. The driver-setup register takes its value as soon as the sixteenth serial clock of a frame arrives. Position, stop and PWM settings take their value when the select line is released. Each channel's mode, voltage, cycle, enable/rate and pulse settings are staged first in a private cache. They all move to the active outputs together when a frame that writes that channel's pulse register ends.

Top module: `sif_serial_regfile`

## Requirements
- R1: SDAT is sampled on rising SCLK edges while CS_N is low, MSB first. Bits [15:12] of the frame are the address and bits [11:0] are the data.
- R2: After power-on reset, both channels show volt=0x20 and cycle=0x00FF. Clock divider=1. Every other output is 0.
- R3: Address 0xD updates the driver setup at the sixteenth SCLK rise, while CS_N is still low. Fields: [2:0] clock divider, [3] current select, [5:4] chopping mode.
- R4: These registers update only when CS_N rises at the end of a frame:
  - PWM at 0xC: [10:9] control, [8:7] chop, [6:0] duty.
  - Stop bit [0] at 0x5 (channel A) and 0xB (channel B).
  - Position from bits [11:10] of the pulse frame.
- R5: Channel writes go to the cache and do not change the outputs. Channel A uses 0x0-0x3 and channel B uses 0x6-0x9: base+0 holds [8:7] mode and [6:0] volt, base+1 holds cycle[7:0], base+2 holds cycle[15:8], base+3 holds [1] enable and [0] rate.
- R6: A frame to a pulse address (0x4 for A, 0xA for B; data [9:0] is the pulse) moves all of that channel's cached values, plus the new pulse, to the outputs when CS_N rises.
- R7: A pulse commit on one channel leaves the other channel's outputs unchanged.
- R8: A frame with fewer than 16 SCLK rises changes nothing. A frame with more than 16 commits nothing at CS_N release, and the next frame is received normally.
- R9: A frame to 0xF with data bit [0] set returns every register, caches included, to its reset value at the sixteenth SCLK rise.
- R10: Frames to address 0xE change no output.
- R11: A frame counts as complete when its sixteenth SCLK rise and the CS_N rise reach the system clock in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdat | input | 1 | Serial data |
| cha_mode | output | 2 | Channel A active mode |
| cha_volt | output | 7 | Channel A active voltage code |
| cha_cycle | output | 16 | Channel A active cycle |
| cha_en | output | 1 | Channel A active enable |
| cha_rate | output | 1 | Channel A active rate |
| cha_pulse | output | 10 | Channel A active pulse count |
| cha_pos | output | 2 | Channel A position |
| cha_stop | output | 1 | Channel A stop |
| chb_mode | output | 2 | Channel B active mode |
| chb_volt | output | 7 | Channel B active voltage code |
| chb_cycle | output | 16 | Channel B active cycle |
| chb_en | output | 1 | Channel B active enable |
| chb_rate | output | 1 | Channel B active rate |
| chb_pulse | output | 10 | Channel B active pulse count |
| chb_pos | output | 2 | Channel B position |
| chb_stop | output | 1 | Channel B stop |
| pwm_ctl | output | 2 | PWM control |
| pwm_chop | output | 2 | PWM chop setting |
| pwm_duty | output | 7 | PWM duty |
| drv_clkdiv | output | 3 | Driver clock divider |
| drv_isel | output | 1 | Driver current select |
| drv_chopmode | output | 2 | Driver chopping mode |

## Verification
Two events can land in the same system-clock cycle: detecting the final (sixteenth) serial clock rise and detecting the select release. The bench provokes this by raising SCLK and CS_N in the same time step for that last bit, so both pass through identical synchronizer chains and arrive together. This is judged correct if the frame still counts as complete. For a stop frame, the stop output must take its new value. For a driver-setup frame, the early (sixteenth-clock) commit must still happen as well.

// File: rtl/sif_pkg.sv
package sif_pkg;
   localparam int ADDR_W    = 4;
   localparam int DATA_W    = 12;
   localparam int FRAME_W   = ADDR_W + DATA_W;
   localparam int MODE_W    = 2;
   localparam int VOLT_W    = 7;
   localparam int CYC_W     = 16;
   localparam int PULSE_W   = 10;
   localparam int POS_W     = 2;
   localparam int CH_STRIDE = 6;

   localparam logic [ADDR_W-1:0] OFS_CFG = 4'd0;
   localparam logic [ADDR_W-1:0] OFS_CYL = 4'd1;
   localparam logic [ADDR_W-1:0] OFS_CYH = 4'd2;
   localparam logic [ADDR_W-1:0] OFS_CTL = 4'd3;
   localparam logic [ADDR_W-1:0] OFS_PLS = 4'd4;
   localparam logic [ADDR_W-1:0] OFS_STP = 4'd5;

   localparam logic [ADDR_W-1:0] ADR_PWM = 4'hC;
   localparam logic [ADDR_W-1:0] ADR_DRV = 4'hD;
   localparam logic [ADDR_W-1:0] ADR_CMD = 4'hF;

   typedef struct packed {
      logic [MODE_W-1:0]  mode;
      logic [VOLT_W-1:0]  volt;
      logic [CYC_W-1:0]   cycle;
      logic               en;
      logic               rate;
      logic [PULSE_W-1:0] pulse;
   } chan_set_t;

   typedef struct packed {
      logic [1:0] ctl;
      logic [1:0] chop;
      logic [6:0] duty;
   } pwm_set_t;

   typedef struct packed {
      logic [1:0] chopmode;
      logic       isel;
      logic [2:0] clkdiv;
   } drv_set_t;
endpackage

// File: rtl/sif_frame_rx.sv
module sif_frame_rx #(
   parameter int SYNC_STAGES = 2,
   parameter int FRAME_W     = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               sclk,
   input  logic               sdat,
   output logic               bit16_vld,
   output logic               frame_end,
   output logic [FRAME_W-1:0] frame_word
);
   localparam int CNT_W = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

   logic [SYNC_STAGES-1:0] cs_chain, ck_chain, dt_chain;
   logic cs_s, ck_s, dt_s, cs_d, ck_d, take;
   logic [CNT_W-1:0]   cnt, cnt_nx;
   logic [FRAME_W-1:0] sh, sh_nx;

   // synchronizer chains, one per link wire
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_chain <= '1;
         ck_chain <= '0;
         dt_chain <= '0;
      end else begin
         cs_chain <= {cs_chain[SYNC_STAGES-2:0], cs_n};
         ck_chain <= {ck_chain[SYNC_STAGES-2:0], sclk};
         dt_chain <= {dt_chain[SYNC_STAGES-2:0], sdat};
      end
   end

   assign cs_s = cs_chain[SYNC_STAGES-1];
   assign ck_s = ck_chain[SYNC_STAGES-1];
   assign dt_s = dt_chain[SYNC_STAGES-1];

   // a clock rise counts if select was low in the previous cycle
   assign take = ck_s & ~ck_d & ~cs_d;

   always_comb begin
      cnt_nx = cnt;
      sh_nx  = sh;
      if (take) begin
         sh_nx = {sh[FRAME_W-2:0], dt_s};
         if (cnt != CNT_OVER) cnt_nx = cnt + CNT_W'(1);
      end
   end

   assign bit16_vld  = take && (cnt == CNT_LAST);
   assign frame_end  = cs_s && !cs_d && (cnt_nx == CNT_FULL);
   assign frame_word = sh_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d <= 1'b1;
         ck_d <= 1'b0;
         cnt  <= '0;
         sh   <= '0;
      end else begin
         cs_d <= cs_s;
         ck_d <= ck_s;
         sh   <= sh_nx;
         cnt  <= cs_d ? '0 : cnt_nx;
      end
   end
endmodule

// File: rtl/sif_chan_regs.sv
module sif_chan_regs
   import sif_pkg::*;
#(
   parameter logic [ADDR_W-1:0] BASE       = '0,
   parameter logic [VOLT_W-1:0] INIT_VOLT  = 7'h20,
   parameter logic [CYC_W-1:0]  INIT_CYCLE = 16'h00FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_vld,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output chan_set_t         act_o,
   output logic [POS_W-1:0]  pos_o,
   output logic              stop_o
);
   localparam chan_set_t INIT = '{mode: '0, volt: INIT_VOLT, cycle: INIT_CYCLE,
                                  en: 1'b0, rate: 1'b0, pulse: '0};
   localparam int HALF = CYC_W / 2;

   chan_set_t         cache, act;
   logic [ADDR_W-1:0] ofs;
   logic              hit;

   assign ofs = wr_addr - BASE;
   assign hit = wr_vld && (wr_addr >= BASE) && (ofs < ADDR_W'(CH_STRIDE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cache  <= INIT;
         act    <= INIT;
         pos_o  <= '0;
         stop_o <= 1'b0;
      end else if (clr) begin
         cache  <= INIT;
         act    <= INIT;
         pos_o  <= '0;
         stop_o <= 1'b0;
      end else if (hit) begin
         case (ofs)
            OFS_CFG: begin
               cache.mode <= wr_data[MODE_W+VOLT_W-1:VOLT_W];
               cache.volt <= wr_data[VOLT_W-1:0];
            end
            OFS_CYL: cache.cycle[HALF-1:0]     <= wr_data[HALF-1:0];
            OFS_CYH: cache.cycle[CYC_W-1:HALF] <= wr_data[HALF-1:0];
            OFS_CTL: begin
               cache.en   <= wr_data[1];
               cache.rate <= wr_data[0];
            end
            OFS_PLS: begin
               cache.pulse <= wr_data[PULSE_W-1:0];
               act         <= cache;
               act.pulse   <= wr_data[PULSE_W-1:0];
               pos_o       <= wr_data[DATA_W-1:DATA_W-POS_W];
            end
            OFS_STP: stop_o <= wr_data[0];
            default: ;
         endcase
      end
   end

   assign act_o = act;
endmodule

// File: rtl/sif_glob_regs.sv
module sif_glob_regs
   import sif_pkg::*;
#(
   parameter logic [2:0] INIT_CLKDIV = 3'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              imm_vld,
   input  logic              end_vld,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output pwm_set_t          pwm_o,
   output drv_set_t          drv_o
);
   localparam int PWM_BITS = $bits(pwm_set_t);
   localparam int DRV_BITS = $bits(drv_set_t);
   localparam drv_set_t DRV_INIT = '{chopmode: '0, isel: 1'b0, clkdiv: INIT_CLKDIV};

   wire unused_hi = ^data[DATA_W-1:PWM_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_o <= '0;
         drv_o <= DRV_INIT;
      end else if (clr) begin
         pwm_o <= '0;
         drv_o <= DRV_INIT;
      end else begin
         if (imm_vld && addr == ADR_DRV) drv_o <= drv_set_t'(data[DRV_BITS-1:0]);
         if (end_vld && addr == ADR_PWM) pwm_o <= pwm_set_t'(data[PWM_BITS-1:0]);
      end
   end
endmodule

// File: rtl/sif_serial_regfile.sv
module sif_serial_regfile
   import sif_pkg::*;
#(
   parameter int          SYNC_STAGES = 2,
   parameter logic [6:0]  INIT_VOLT   = 7'h20,
   parameter logic [15:0] INIT_CYCLE  = 16'h00FF,
   parameter logic [2:0]  INIT_CLKDIV = 3'd1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_n,
   input  logic        sclk,
   input  logic        sdat,
   output logic [1:0]  cha_mode,
   output logic [6:0]  cha_volt,
   output logic [15:0] cha_cycle,
   output logic        cha_en,
   output logic        cha_rate,
   output logic [9:0]  cha_pulse,
   output logic [1:0]  cha_pos,
   output logic        cha_stop,
   output logic [1:0]  chb_mode,
   output logic [6:0]  chb_volt,
   output logic [15:0] chb_cycle,
   output logic        chb_en,
   output logic        chb_rate,
   output logic [9:0]  chb_pulse,
   output logic [1:0]  chb_pos,
   output logic        chb_stop,
   output logic [1:0]  pwm_ctl,
   output logic [1:0]  pwm_chop,
   output logic [6:0]  pwm_duty,
   output logic [2:0]  drv_clkdiv,
   output logic        drv_isel,
   output logic [1:0]  drv_chopmode
);
   localparam int NUM_CH = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NUM_CH * CH_STRIDE > int'(ADR_PWM)) begin : g_bad_map
      $error("channel windows overlap the shared registers");
   end

   logic               bit16_vld, frame_end, cmd_rst;
   logic [FRAME_W-1:0] frame_word;
   logic [ADDR_W-1:0]  addr;
   logic [DATA_W-1:0]  data;
   chan_set_t          ch_act [NUM_CH];
   logic [POS_W-1:0]   ch_pos [NUM_CH];
   logic               ch_stop[NUM_CH];
   pwm_set_t           pwm;
   drv_set_t           drv;

   sif_frame_rx #(.SYNC_STAGES(SYNC_STAGES), .FRAME_W(FRAME_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdat(sdat),
      .bit16_vld(bit16_vld), .frame_end(frame_end), .frame_word(frame_word)
   );

   assign addr    = frame_word[FRAME_W-1 -: ADDR_W];
   assign data    = frame_word[DATA_W-1:0];
   assign cmd_rst = bit16_vld && (addr == ADR_CMD) && data[0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      sif_chan_regs #(
         .BASE(ADDR_W'(c * CH_STRIDE)), .INIT_VOLT(INIT_VOLT), .INIT_CYCLE(INIT_CYCLE)
      ) u_ch (
         .clk(clk), .rst_n(rst_n), .clr(cmd_rst), .wr_vld(frame_end),
         .wr_addr(addr), .wr_data(data),
         .act_o(ch_act[c]), .pos_o(ch_pos[c]), .stop_o(ch_stop[c])
      );
   end

   sif_glob_regs #(.INIT_CLKDIV(INIT_CLKDIV)) u_glob (
      .clk(clk), .rst_n(rst_n), .clr(cmd_rst), .imm_vld(bit16_vld),
      .end_vld(frame_end), .addr(addr), .data(data), .pwm_o(pwm), .drv_o(drv)
   );

   assign cha_mode  = ch_act[0].mode;
   assign cha_volt  = ch_act[0].volt;
   assign cha_cycle = ch_act[0].cycle;
   assign cha_en    = ch_act[0].en;
   assign cha_rate  = ch_act[0].rate;
   assign cha_pulse = ch_act[0].pulse;
   assign cha_pos   = ch_pos[0];
   assign cha_stop  = ch_stop[0];
   assign chb_mode  = ch_act[1].mode;
   assign chb_volt  = ch_act[1].volt;
   assign chb_cycle = ch_act[1].cycle;
   assign chb_en    = ch_act[1].en;
   assign chb_rate  = ch_act[1].rate;
   assign chb_pulse = ch_act[1].pulse;
   assign chb_pos   = ch_pos[1];
   assign chb_stop  = ch_stop[1];

   assign pwm_ctl      = pwm.ctl;
   assign pwm_chop     = pwm.chop;
   assign pwm_duty     = pwm.duty;
   assign drv_clkdiv   = drv.clkdiv;
   assign drv_isel     = drv.isel;
   assign drv_chopmode = drv.chopmode;
endmodule

// File: rtl/sif_serial_regfile_chk.sv
module sif_serial_regfile_chk
   import sif_pkg::*;
#(
   parameter logic [2:0] INIT_CLKDIV = 3'd1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit16_vld,
   input logic              frame_end,
   input logic              cmd_rst,
   input logic [ADDR_W-1:0] addr,
   input logic [1:0]        cha_mode,
   input logic [9:0]        cha_pulse,
   input logic [9:0]        chb_pulse,
   input logic [6:0]        pwm_duty,
   input logic [2:0]        drv_clkdiv
);
   localparam logic [ADDR_W-1:0] A_PLS = OFS_PLS;
   localparam logic [ADDR_W-1:0] B_PLS = OFS_PLS + ADDR_W'(CH_STRIDE);

   assert_drv_only_at_bit16_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bit16_vld |=> $stable(drv_clkdiv));

   assert_pwm_only_at_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_end && !cmd_rst) |=> $stable(pwm_duty));

   assert_cha_mode_held_in_cache_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_end && addr == A_PLS) && !cmd_rst |=> $stable(cha_mode));

   assert_cha_pulse_commit_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_end && addr == A_PLS) && !cmd_rst |=> $stable(cha_pulse));

   assert_other_channel_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && addr == A_PLS && !cmd_rst) |=> $stable(chb_pulse));

   assert_cmd_reset_values_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_rst |=> (cha_mode == 2'd0 && drv_clkdiv == INIT_CLKDIV && chb_pulse == '0));

   assert_b_pulse_commit_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_end && addr == B_PLS) && !cmd_rst |=> $stable(chb_pulse));
endmodule

bind sif_serial_regfile sif_serial_regfile_chk #(.INIT_CLKDIV(INIT_CLKDIV)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit16_vld(bit16_vld), .frame_end(frame_end),
   .cmd_rst(cmd_rst), .addr(addr), .cha_mode(cha_mode), .cha_pulse(cha_pulse),
   .chb_pulse(chb_pulse), .pwm_duty(pwm_duty), .drv_clkdiv(drv_clkdiv)
);

// File: tb/sif_serial_regfile_tb.sv
module sif_serial_regfile_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, sdat = 1'b0;
   logic [1:0] cha_mode, cha_pos, chb_mode, chb_pos, pwm_ctl, pwm_chop, drv_chopmode;
   logic [6:0] cha_volt, chb_volt, pwm_duty;
   logic [15:0] cha_cycle, chb_cycle;
   logic cha_en, cha_rate, cha_stop, chb_en, chb_rate, chb_stop, drv_isel;
   logic [9:0] cha_pulse, chb_pulse;
   logic [2:0] drv_clkdiv;
   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sif_serial_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdat(sdat),
      .cha_mode(cha_mode), .cha_volt(cha_volt), .cha_cycle(cha_cycle), .cha_en(cha_en),
      .cha_rate(cha_rate), .cha_pulse(cha_pulse), .cha_pos(cha_pos), .cha_stop(cha_stop),
      .chb_mode(chb_mode), .chb_volt(chb_volt), .chb_cycle(chb_cycle), .chb_en(chb_en),
      .chb_rate(chb_rate), .chb_pulse(chb_pulse), .chb_pos(chb_pos), .chb_stop(chb_stop),
      .pwm_ctl(pwm_ctl), .pwm_chop(pwm_chop), .pwm_duty(pwm_duty),
      .drv_clkdiv(drv_clkdiv), .drv_isel(drv_isel), .drv_chopmode(drv_chopmode)
   );

   // observation codes: 0 A mode, 1 A volt, 2 A cycle, 3 A {en,rate}, 4 A pulse, 5 A pos,
   // 6 A stop, 7..13 same for B, 14 {ctl,chop,duty}, 15 {chopmode,isel,clkdiv}
   function automatic logic [15:0] obs(input int code);
      case (code)
         0: return 16'(cha_mode);   1: return 16'(cha_volt);   2: return cha_cycle;
         3: return 16'({cha_en, cha_rate});   4: return 16'(cha_pulse);
         5: return 16'(cha_pos);    6: return 16'(cha_stop);
         7: return 16'(chb_mode);   8: return 16'(chb_volt);   9: return chb_cycle;
         10: return 16'({chb_en, chb_rate});  11: return 16'(chb_pulse);
         12: return 16'(chb_pos);   13: return 16'(chb_stop);
         14: return 16'({pwm_ctl, pwm_chop, pwm_duty});
         default: return 16'({drv_chopmode, drv_isel, drv_clkdiv});
      endcase
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] w, input int nbits, input bit coinc, input bit hold);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdat = (i < 16) ? w[15-i] : 1'b0;
         repeat (4) @(negedge clk);
         sclk = 1'b1;
         if (coinc && i == nbits - 1) cs_n = 1'b1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
      end
      if (!coinc && !hold) begin
         repeat (4) @(negedge clk);
         cs_n = 1'b1;
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic release_cs();
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   // {word[43:28], obs code[27:20], expected[19:4], requirement[3:0]}
   localparam int NV = 25;
   localparam logic [43:0] VEC [NV] = '{
      {16'h0135, 8'd0,  16'h0000, 4'd5},   // R5 A mode/volt cached
      {16'h1034, 8'd2,  16'h00FF, 4'd5},   // R5 A cycle low cached
      {16'h2012, 8'd2,  16'h00FF, 4'd5},   // R5 A cycle high cached
      {16'h3003, 8'd3,  16'h0000, 4'd5},   // R5 A en/rate cached
      {16'h4D55, 8'd4,  16'h0155, 4'd6},   // R6 A pulse commit
      {16'h4D55, 8'd0,  16'h0002, 4'd6},   // R6
      {16'h4D55, 8'd1,  16'h0035, 4'd6},   // R6
      {16'h4D55, 8'd2,  16'h1234, 4'd6},   // R6, R1 MSB-first assembly
      {16'h4D55, 8'd3,  16'h0003, 4'd6},   // R6
      {16'h4D55, 8'd5,  16'h0003, 4'd4},   // R4 position
      {16'h4D55, 8'd7,  16'h0000, 4'd7},   // R7 B untouched
      {16'h60FF, 8'd7,  16'h0000, 4'd5},   // R5 B cached
      {16'hA7FF, 8'd7,  16'h0001, 4'd6},   // R6 B commit
      {16'hA7FF, 8'd8,  16'h007F, 4'd6},   // R6
      {16'hA7FF, 8'd11, 16'h03FF, 4'd6},   // R6
      {16'hA7FF, 8'd0,  16'h0002, 4'd7},   // R7 A untouched
      {16'hA7FF, 8'd9,  16'h00FF, 4'd6},   // R6 B cycle stays at reset
      {16'hC35A, 8'd14, 16'h035A, 4'd4},   // R4 PWM
      {16'hD02D, 8'd15, 16'h002D, 4'd3},   // R3 driver setup
      {16'hEFFF, 8'd15, 16'h002D, 4'd10},  // R10 undefined address
      {16'hEFFF, 8'd14, 16'h035A, 4'd10},  // R10
      {16'h5001, 8'd6,  16'h0001, 4'd4},   // R4 A stop
      {16'hB001, 8'd13, 16'h0001, 4'd4},   // R4 B stop
      {16'hB000, 8'd13, 16'h0000, 4'd4},   // R4
      {16'h0000, 8'd0,  16'h0002, 4'd5}    // R5 rewrite cache only
   };

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R2 reset state
      chk("R2 a_volt",  obs(1),  16'h0020);
      chk("R2 a_cycle", obs(2),  16'h00FF);
      chk("R2 b_cycle", obs(9),  16'h00FF);
      chk("R2 a_mode",  obs(0),  16'h0000);
      chk("R2 pwm",     obs(14), 16'h0000);
      chk("R2 drv",     obs(15), 16'h0001);

      for (int i = 0; i < NV; i++) begin
         send(VEC[i][43:28], 16, 1'b0, 1'b0);
         chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), obs(int'(VEC[i][27:20])), VEC[i][19:4]);
      end

      // R3: driver setup visible while CS_N still low
      send(16'hD013, 16, 1'b0, 1'b1);
      chk("R3 drv before release", obs(15), 16'h0013);
      release_cs();
      // R4: PWM not visible before release
      send(16'hC07F, 16, 1'b0, 1'b1);
      chk("R4 pwm before release", obs(14), 16'h035A);
      release_cs();
      chk("R4 pwm after release", obs(14), 16'h007F);

      // R8: short and long frames
      send(16'hD02D, 15, 1'b0, 1'b0);
      chk("R8 short frame", obs(15), 16'h0013);
      send(16'hC123, 17, 1'b0, 1'b0);
      chk("R8 long frame", obs(14), 16'h007F);
      send(16'hC07E, 16, 1'b0, 1'b0);
      chk("R8 recovery", obs(14), 16'h007E);

      // R11: last clock rise and release together
      send(16'h5000, 16, 1'b1, 1'b0);
      chk("R11 stop coincident", obs(6), 16'h0000);
      send(16'hD02D, 16, 1'b1, 1'b0);
      chk("R11 drv coincident", obs(15), 16'h002D);

      // R9: command reset, caches included
      send(16'hF001, 16, 1'b0, 1'b0);
      chk("R9 a_mode",  obs(0),  16'h0000);
      chk("R9 a_cycle", obs(2),  16'h00FF);
      chk("R9 a_pos",   obs(5),  16'h0000);
      chk("R9 b_pulse", obs(11), 16'h0000);
      chk("R9 b_volt",  obs(8),  16'h0020);
      chk("R9 pwm",     obs(14), 16'h0000);
      chk("R9 drv",     obs(15), 16'h0001);
      send(16'h4000, 16, 1'b0, 1'b0);
      chk("R9 cache cleared", obs(2), 16'h00FF);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R1 watchdog actual=timeout expected=complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule